// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block carries 36-bit words from one clock domain to another through a dual-port RAM. The two clocks need not be related. The producer sees a ready flag that stays high while there is room, and an active-low "nearly full" flag. The consumer sees a valid flag that marks the word at the head, and an active-low "nearly empty" flag. The head word already sits in an output register, so the consumer can read it before it asserts its read enable.

Both thresholds are set when reset is released. There are two ways to set them. A two-bit select input can pick one of three fixed values, and that value is then used for both thresholds. If the select input is zero, the first four words accepted on the write port are configuration words and are not stored as data. In order, they set the nearly-empty threshold of this FIFO, its nearly-full threshold, and then two threshold values for a companion FIFO running the other way. The block only holds those last two values and drives them out on ports.

Top module: `xclk_flag_fifo`

## Requirements
- R1: While `rstN` is low, `inReady` is 0, `outReady` is 0, `almostEmptyN` is 0 and `almostFullN` is 1. Any stored words are discarded, so `outReady` stays 0 after release until a new word is written.
- R2: After `rstN` rises, `inReady` is still 0 after the first rising edge of `wrClk`. It is 1 after the second rising edge.
- R3: `flagSel` is sampled on the first `wrClk` edge after release. Code 01 sets both thresholds and both companion outputs to 8, code 10 sets them to 16, and code 11 sets them to 64.
- R4: With `flagSel` = 00, the first four accepted writes set, in this order: the nearly-empty threshold, the nearly-full threshold, `peerEmptyOfs` and `peerFullOfs`. Each value is taken from bits [OFS_W-1:0] of the word (9 bits at depth 256). These four words are never delivered on the read side. The first data word is the fifth accepted write.
- R5: Words leave in the order they were accepted. While `outReady` is 1 and `rdEn` is 0, `rdData` holds its value. `outReady` falls only after a read.
- R6: When a word is written into an empty FIFO, `outReady` is 0 after the second rising edge of `rdClk` that follows the write edge. It is 1, with the word on `rdData`, after the third.
- R7: `almostEmptyN` is 0 when the number of words held is less than or equal to the nearly-empty threshold. The word in the output register is included in that count.
- R8: `almostFullN` is 0 when DEPTH minus the number of words in the RAM is less than or equal to the nearly-full threshold. The word already moved to the output register is not counted.
- R9: `inReady` falls when the RAM holds DEPTH words. A write offered while `inReady` is 0 is dropped. With an idle reader, DEPTH+1 words fit in total.
- R10: `rdEn` has no effect while `outReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Active-low reset. Hold it low for at least four edges of each clock |
| flagSel | input | 2 | Threshold preset code, sampled after release |
| wrEn | input | 1 | Write request. It is taken on a `wrClk` edge when `inReady` is 1 |
| wrData | input | 36 | Write word, or a configuration word while thresholds are being loaded |
| inReady | output | 1 | Room available (write domain) |
| almostFullN | output | 1 | Nearly-full flag, active low (write domain) |
| rdEn | input | 1 | Read request. It consumes the head word when `outReady` is 1 |
| rdData | output | 36 | Head word |
| outReady | output | 1 | Head word valid (read domain) |
| almostEmptyN | output | 1 | Nearly-empty flag, active low (read domain) |
| peerEmptyOfs | output | OFS_W | Nearly-empty threshold held for the companion FIFO |
| peerFullOfs | output | OFS_W | Nearly-full threshold held for the companion FIFO |

## Verification
Two pairs of events can fall on the same edge. On the read side, a read can consume the output register on the same edge that the next word is loaded into it. On the write side, a write can be accepted on the very edge at which the RAM becomes full. The bench provokes both with random traffic that is write-heavy at first, so the FIFO sits at full for long stretches, and read-heavy later, so reads and reloads run back to back. The result is judged against an ordered model of every accepted word. Directed cases pin down the exact edge at which each flag moves.

// File: rtl/xff_pkg.sv
`timescale 1ns/1ps
package xff_pkg;
  localparam int DATA_W = 36;

  // strobes from control to datapath, one per clock domain
  typedef struct packed {
    logic wrStb;   // write the current word into the RAM (write clock)
    logic rdLoad;  // move the RAM head into the output register (read clock)
  } xff_strobe_t;

  typedef enum logic [1:0] {
    SEL_LOAD = 2'b00,
    SEL_P8   = 2'b01,
    SEL_P16  = 2'b10,
    SEL_P64  = 2'b11
  } xff_sel_e;

  function automatic int unsigned presetOfs(input xff_sel_e sel);
    case (sel)
      SEL_P8:  return 8;
      SEL_P16: return 16;
      SEL_P64: return 64;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/xff_gray_sync.sv
`timescale 1ns/1ps
module xff_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      binOut[i] = ^(stage2 >> i);
    end
  end
endmodule

// File: rtl/xff_ctrl.sv
`timescale 1ns/1ps
module xff_ctrl
  import xff_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int OFS_W = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic [1:0]       flagSel,
  input  logic             wrEn,
  input  logic [OFS_W-1:0] cfgWord,
  input  logic             rdEn,
  output xff_strobe_t      strobe,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             inReady,
  output logic             almostFullN,
  output logic             outReady,
  output logic             almostEmptyN,
  output logic [OFS_W-1:0] peerEmptyOfs,
  output logic [OFS_W-1:0] peerFullOfs
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  // ---------------- write domain ----------------
  logic [PW-1:0]    wrBin, wrGray, wrBinNext, rdBinSync, usedNext, freeNext;
  logic [OFS_W-1:0] emptyOfs, fullOfs, pEmptyOfs, pFullOfs;
  logic [2:0]       loadIdx;
  logic             armed, inReadyQ, afNQ, cfgDone, wrAccept, dataWr, fullNext;

  assign cfgDone   = loadIdx[2];
  assign wrAccept  = wrEn & inReadyQ;
  assign dataWr    = wrAccept & cfgDone;
  assign wrBinNext = wrBin + PW'(dataWr);
  assign usedNext  = wrBinNext - rdBinSync;
  assign fullNext  = (usedNext == DEPTH_P);
  assign freeNext  = DEPTH_P - usedNext;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin     <= '0;
      wrGray    <= '0;
      armed     <= 1'b0;
      inReadyQ  <= 1'b0;
      afNQ      <= 1'b1;
      loadIdx   <= 3'd0;
      emptyOfs  <= '0;
      fullOfs   <= '0;
      pEmptyOfs <= '0;
      pFullOfs  <= '0;
    end else begin
      armed <= 1'b1;
      if (!armed) begin
        if (xff_sel_e'(flagSel) == SEL_LOAD) begin
          loadIdx <= 3'd0;
        end else begin
          emptyOfs  <= OFS_W'(presetOfs(xff_sel_e'(flagSel)));
          fullOfs   <= OFS_W'(presetOfs(xff_sel_e'(flagSel)));
          pEmptyOfs <= OFS_W'(presetOfs(xff_sel_e'(flagSel)));
          pFullOfs  <= OFS_W'(presetOfs(xff_sel_e'(flagSel)));
          loadIdx   <= 3'd4;
        end
      end else if (wrAccept && !cfgDone) begin
        case (loadIdx[1:0])
          2'd0:    emptyOfs  <= cfgWord;
          2'd1:    fullOfs   <= cfgWord;
          2'd2:    pEmptyOfs <= cfgWord;
          default: pFullOfs  <= cfgWord;
        endcase
        loadIdx <= loadIdx + 3'd1;
      end
      wrBin    <= wrBinNext;
      wrGray   <= wrBinNext ^ (wrBinNext >> 1);
      inReadyQ <= armed & ~fullNext;
      afNQ     <= ~(freeNext <= fullOfs);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, rdBinNext, wrBinSync;
  logic [PW:0]   countNext;
  logic          outValid, aeNQ, ramEmpty, loadHead, outValidNext;

  assign ramEmpty     = (wrBinSync == rdBin);
  assign loadHead     = ~ramEmpty & (~outValid | rdEn);
  assign rdBinNext    = rdBin + PW'(loadHead);
  assign outValidNext = loadHead | (outValid & ~rdEn);
  assign countNext    = {1'b0, wrBinSync - rdBinNext} + (PW+1)'(outValidNext);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
      aeNQ     <= 1'b0;
    end else begin
      rdBin    <= rdBinNext;
      rdGray   <= rdBinNext ^ (rdBinNext >> 1);
      outValid <= outValidNext;
      // emptyOfs is written only while the FIFO is empty, where the flag is low anyway
      aeNQ     <= ~(countNext <= {1'b0, emptyOfs});
    end
  end

  // ---------------- pointer crossings ----------------
  xff_gray_sync #(.W(PW)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .grayIn(rdGray), .binOut(rdBinSync)
  );
  xff_gray_sync #(.W(PW)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .grayIn(wrGray), .binOut(wrBinSync)
  );

  assign strobe.wrStb  = dataWr;
  assign strobe.rdLoad = loadHead;
  assign wrAddr        = wrBin[AW-1:0];
  assign rdAddr        = rdBin[AW-1:0];
  assign inReady       = inReadyQ;
  assign almostFullN   = afNQ;
  assign outReady      = outValid;
  assign almostEmptyN  = aeNQ;
  assign peerEmptyOfs  = pEmptyOfs;
  assign peerFullOfs   = pFullOfs;
endmodule

// File: rtl/xff_datapath.sv
`timescale 1ns/1ps
module xff_datapath
  import xff_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  xff_strobe_t       strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStb) ram[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdLoad) rdData <= ram[rdAddr];
  end
endmodule

// File: rtl/xclk_flag_fifo.sv
`timescale 1ns/1ps
module xclk_flag_fifo
  import xff_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int OFS_W = AW + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [1:0]        flagSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              inReady,
  output logic              almostFullN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              outReady,
  output logic              almostEmptyN,
  output logic [OFS_W-1:0]  peerEmptyOfs,
  output logic [OFS_W-1:0]  peerFullOfs
);
  xff_strobe_t   strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  xff_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .flagSel(flagSel),
    .wrEn(wrEn), .cfgWord(wrData[OFS_W-1:0]), .rdEn(rdEn),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inReady(inReady), .almostFullN(almostFullN),
    .outReady(outReady), .almostEmptyN(almostEmptyN),
    .peerEmptyOfs(peerEmptyOfs), .peerFullOfs(peerFullOfs)
  );

  xff_datapath #(.DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/xff_checker.sv
`timescale 1ns/1ps
module xff_checker (
  input logic        wrClk,
  input logic        rdClk,
  input logic        rstN,
  input logic        inReady,
  input logic        almostFullN,
  input logic        rdEn,
  input logic        outReady,
  input logic [35:0] rdData,
  input logic        almostEmptyN
);
  p_hold_head_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    (outReady && !rdEn) |=> (outReady && $stable(rdData)));

  p_drop_after_read_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(outReady) |-> $past(rdEn));

  p_empty_is_low_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    !outReady |-> !almostEmptyN);

  p_full_marks_af_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(inReady) |-> !almostFullN);
endmodule

bind xclk_flag_fifo xff_checker u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .inReady(inReady),
  .almostFullN(almostFullN), .rdEn(rdEn), .outReady(outReady),
  .rdData(rdData), .almostEmptyN(almostEmptyN)
);

// File: tb/tb_xclk_flag_fifo.sv
`timescale 1ns/1ps
module tb_xclk_flag_fifo;
  localparam real WR_PERIOD = 10.0;
  localparam real RD_PERIOD = 13.0;
  localparam int  DEPTH     = 256;
  localparam int  OFS_W     = 9;

  logic wrClk, rdClk, rstN, wrEn, rdEn;
  logic [1:0] flagSel;
  logic [35:0] wrData, rdData;
  logic inReady, almostFullN, outReady, almostEmptyN;
  logic [OFS_W-1:0] peerEmptyOfs, peerFullOfs;

  int nPass = 0, nFail = 0, cfgLeft = 0;
  bit wDone;
  logic [35:0] sb [$];

  xclk_flag_fifo #(.DEPTH(DEPTH)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .flagSel(flagSel),
    .wrEn(wrEn), .wrData(wrData), .inReady(inReady), .almostFullN(almostFullN),
    .rdEn(rdEn), .rdData(rdData), .outReady(outReady), .almostEmptyN(almostEmptyN),
    .peerEmptyOfs(peerEmptyOfs), .peerFullOfs(peerFullOfs)
  );

  initial begin wrClk = 0; forever #(WR_PERIOD/2) wrClk = ~wrClk; end
  // offset start so that no read edge ever meets a write edge
  initial begin rdClk = 0; #0.8; forever #(RD_PERIOD/2) rdClk = ~rdClk; end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    if (act === exp) nPass++;
    else begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitWr(input int n); repeat (n) @(posedge wrClk); #1; endtask
  task automatic waitRd(input int n); repeat (n) @(posedge rdClk); #1; endtask

  // offer one word; returns whether it was taken
  task automatic put(input logic [35:0] d, output bit acc);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d; acc = inReady;
    @(posedge wrClk);
    wrEn <= 1'b0;
    if (acc) begin
      if (cfgLeft > 0) cfgLeft--;
      else sb.push_back(d);
    end
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (sb.size() > 0 && guard < 5000) begin
      @(negedge rdClk);
      guard++;
      if (outReady) begin
        chk(req, rdData, sb[0]);
        void'(sb.pop_front());
        rdEn = 1'b1;
        @(posedge rdClk);
        rdEn <= 1'b0;
      end
    end
    chk(req, sb.size(), 0);
  endtask

  task automatic doReset(input logic [1:0] sel);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; flagSel = sel;
    sb.delete();
    cfgLeft = (sel == 2'b00) ? 4 : 0;
    waitWr(6);
    chk("R1 inReady", inReady, 0);
    chk("R1 outReady", outReady, 0);
    chk("R1 almostEmptyN", almostEmptyN, 0);
    chk("R1 almostFullN", almostFullN, 1);
    @(negedge wrClk); rstN = 1'b1;
    waitWr(1); chk("R2 first edge", inReady, 0);
    waitWr(1); chk("R2 second edge", inReady, 1);
  endtask

  initial begin
    bit acc;
    logic [35:0] word;
    void'($urandom(32'd2024));
    rstN = 0; wrEn = 0; rdEn = 0; flagSel = 2'b01; wrData = '0;

    // preset 8
    doReset(2'b01);
    chk("R3 peerEmpty p8", peerEmptyOfs, 8);
    chk("R3 peerFull p8", peerFullOfs, 8);

    // R10: read on empty ignored
    @(negedge rdClk); rdEn = 1'b1; @(posedge rdClk); rdEn <= 1'b0; #1;
    chk("R10 empty read", outReady, 0);

    // R6: exact latency into empty
    @(negedge wrClk); wrEn = 1'b1; wrData = 36'h1_2345_6789;
    @(posedge wrClk); wrEn <= 1'b0; sb.push_back(36'h1_2345_6789);
    @(posedge rdClk); @(posedge rdClk); #1;
    chk("R6 after two", outReady, 0);
    @(posedge rdClk); #1;
    chk("R6 after three", outReady, 1);
    chk("R10 head kept", rdData, 36'h1_2345_6789);
    drain("R5 single");

    // R7 with threshold 8
    for (int i = 0; i < 8; i++) put(36'h100 + 36'(i), acc);
    waitRd(8); chk("R7 eight held", almostEmptyN, 0);
    put(36'h108, acc);
    waitRd(8); chk("R7 nine held", almostEmptyN, 1);
    chk("R5 head stable", rdData, sb[0]);

    // R8 / R9: fill with idle reader
    while (sb.size() < 248) put(36'h200 + 36'(sb.size()), acc);
    waitWr(6); chk("R8 free nine", almostFullN, 1);
    put(36'h3F8, acc);
    waitWr(3); chk("R8 free eight", almostFullN, 0);
    while (sb.size() < 256) put(36'h400 + 36'(sb.size()), acc);
    waitWr(3); chk("R9 not yet full", inReady, 1);
    put(36'h5FF, acc);
    waitWr(3); chk("R9 full", inReady, 0);
    chk("R9 count", sb.size(), DEPTH + 1);
    put(36'hD_EAD0_BEEF, acc);
    chk("R9 dropped", acc, 0);
    drain("R5 R9 order");
    waitRd(6); chk("R9 marker absent", outReady, 0);

    // R1 flush, preset 16
    for (int i = 0; i < 3; i++) put(36'h700 + 36'(i), acc);
    doReset(2'b10);
    waitRd(8); chk("R1 flushed", outReady, 0);
    chk("R3 peerEmpty p16", peerEmptyOfs, 16);
    chk("R3 peerFull p16", peerFullOfs, 16);

    // R4 loaded thresholds: 5, 20, 33, 44 in the low 9 bits
    doReset(2'b00);
    put(36'hF_FFFF_FE05, acc);
    put(36'hF_FFFF_FE14, acc);
    put(36'hF_FFFF_FE21, acc);
    put(36'hF_FFFF_FE2C, acc);
    waitWr(2);
    chk("R4 peerEmpty", peerEmptyOfs, 33);
    chk("R4 peerFull", peerFullOfs, 44);
    waitRd(8); chk("R4 cfg not stored", outReady, 0);
    for (int i = 0; i < 5; i++) put(36'h800 + 36'(i), acc);
    waitRd(8); chk("R7 R4 five held", almostEmptyN, 0);
    put(36'h805, acc);
    waitRd(8); chk("R7 R4 six held", almostEmptyN, 1);
    chk("R4 first data", rdData, 36'h800);
    drain("R5 loaded");

    // random traffic, preset 64
    doReset(2'b11);
    chk("R3 peerEmpty p64", peerEmptyOfs, 64);
    chk("R3 peerFull p64", peerFullOfs, 64);
    wDone = 0;
    fork
      begin
        for (int i = 0; i < 1500; i++) begin
          bit en;
          @(negedge wrClk);
          en = (i < 700) ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
          word = {4'($urandom), 32'($urandom)};
          if (en && inReady) sb.push_back(word);
          wrEn = en; wrData = word;
        end
        @(negedge wrClk); wrEn = 1'b0;
        wDone = 1;
      end
      begin
        int rdCycle = 0;
        while (!wDone || sb.size() > 0) begin
          bit en;
          @(negedge rdClk);
          en = wDone ? 1'b1 : ((rdCycle < 900) ? ($urandom % 5 == 0) : ($urandom % 4 != 0));
          if (en && outReady) begin
            chk("R5 random", rdData, sb[0]);
            void'(sb.pop_front());
          end
          rdEn = en;
          rdCycle++;
        end
        @(negedge rdClk); rdEn = 1'b0;
      end
    join
    waitRd(6); chk("R9 R5 drained", outReady, 0);

    $display("%0d/%0d checks passed", nPass, nPass + nFail);
    $finish;
  end

  initial begin
    #(WR_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nPass, nPass + nFail);
    $finish;
  end
endmodule